// File: doc/BRIEF.md
# Line Printer Controller Register Interface

This block sits between a host bus and a character line printer. It provides two 16-bit registers at neighbouring word addresses. The status/control register shows a combined printer fault flag and a ready flag, and it holds a host-writable interrupt enable. The data register accepts one byte at a time. Each accepted byte becomes one transfer to the printer side. The transfer is either a 7-bit ASCII character or a paper-advance command that carries a line count from 0 to 15.

The printer side is a valid/ack stream. After a data write is accepted, `prn_valid` rises. It then stays high, with `prn_adv` and `prn_data` frozen, until the printer pulses `prn_ack` while valid is high. That is the only back-pressure. While a transfer is pending, ready reads 0 and further data writes are dropped. An ack that arrives while valid is low has no effect. The interrupt request is a level signal. A static input `pi_disable` turns off paper-advance decoding.

Top module: `lpt_ctrl`

## Requirements
- R1: After reset: ready = 1, interrupt enable = 0, `prn_valid` = 0, `irq` = 0, and the data register reads 0x0000.
- R2: Reading the status register (word address octal 777514) returns bit 15 = error, bit 7 = ready, bit 6 = interrupt enable, and 0 in every other bit. Writes to any bit except bit 6 have no effect.
- R3: Error reads 1 exactly one clock after any `fault_in` bit is high. It reads 0 one clock after all fault bits are low. A host write cannot set or clear it.
- R4: Writing the status register loads bit 6 of the write data into interrupt enable. The new value is visible one clock after the write edge.
- R5: `irq` is high exactly when interrupt enable is 1 and error or ready is 1.
- R6: A write to the data register (octal 777516) while ready = 1 is accepted. From the next clock on: `prn_valid` = 1, ready = 0, `prn_adv` = 0, and `prn_data` = write bits 6..0. Write bits 15..8 are ignored.
- R7: If `pi_disable` = 0 and write bits 7 and 4 are both 1, the accepted write is a paper advance: `prn_adv` = 1 and `prn_data` = {3'b000, write bits 3..0}.
- R8: If `pi_disable` = 1, or if bit 7 is set without bit 4, the write is sent as a character (`prn_adv` = 0) with `prn_data` = bits 6..0.
- R9: `prn_valid`, `prn_adv` and `prn_data` hold steady until a cycle with `prn_valid` and `prn_ack` both high. On the next clock `prn_valid` = 0 and ready = 1. An ack with valid low changes nothing.
- R10: A data-register write while ready = 0 is discarded. The read-back value and the printer-side payload stay unchanged.
- R11: Reading the data register returns {8'h00, bits 7..0 of the last accepted write}.
- R12: Any other address reads 0x0000. Writes to other addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (bus init) |
| bus_addr | input | 18 | Word address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| fault_in | input | 7 | Printer fault conditions, active high |
| pi_disable | input | 1 | 1 = paper-advance decoding off |
| irq | output | 1 | Level interrupt request |
| prn_valid | output | 1 | Printer transfer pending |
| prn_adv | output | 1 | 1 = paper advance, 0 = character |
| prn_data | output | 7 | Character, or line count in bits 3..0 |
| prn_ack | input | 1 | Printer accepts the pending transfer |

## Verification
Every flag and printer-side output comes from a register, so each one updates at the first clock edge after the write, ack or fault change that causes it. `irq` and `bus_rdata` follow combinationally from those registers and from the address. The bench drives every input on the falling edge. It reads results at the next falling edge, one half period after the edge that registered them, so each check falls exactly one cycle after its stimulus. Hold checks sample the same outputs again one cycle later, with no ack, to confirm they did not move.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int CHAR_W  = 7;
  localparam int CNT_W   = 4;
  localparam int REG_W   = 16;
  localparam int ERR_BIT = 15;
  localparam int RDY_BIT = 7;
  localparam int IE_BIT  = 6;
  localparam int PI_BIT  = 7;
  localparam int ADV_BIT = 4;

  typedef struct packed {
    logic              adv;
    logic [CHAR_W-1:0] data;
  } prn_cmd_t;
endpackage

// File: rtl/lpt_fault_agg.sv
module lpt_fault_agg #(
  parameter int NFAULT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFAULT-1:0] fault_in,
  output logic              err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= |fault_in;
  end

  p_err_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in != '0) |=> err);
  p_err_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in == '0) |=> !err);
endmodule

// File: rtl/lpt_cmd_decode.sv
module lpt_cmd_decode
  import lpt_pkg::*;
(
  input  logic [7:0] wbyte,
  input  logic       pi_disable,
  output prn_cmd_t   cmd
);
  logic is_adv;

  always_comb begin
    is_adv = wbyte[PI_BIT] & wbyte[ADV_BIT] & ~pi_disable;
    cmd.adv = is_adv;
    if (is_adv) cmd.data = {{(CHAR_W-CNT_W){1'b0}}, wbyte[CNT_W-1:0]};
    else        cmd.data = wbyte[CHAR_W-1:0];
  end
endmodule

// File: rtl/lpt_xfer.sv
module lpt_xfer
  import lpt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  prn_cmd_t cmd_in,
  input  logic     ack,
  output logic     valid,
  output logic     ready,
  output prn_cmd_t cmd_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      ready   <= 1'b1;
      cmd_out <= '0;
    end else if (load && ready) begin
      valid   <= 1'b1;
      ready   <= 1'b0;
      cmd_out <= cmd_in;
    end else if (valid && ack) begin
      valid   <= 1'b0;
      ready   <= 1'b1;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ack) |=> (valid && $stable(cmd_out)));
  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ack) |=> (!valid && ready));
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready != valid);
endmodule

// File: rtl/lpt_ctrl.sv
module lpt_ctrl
  import lpt_pkg::*;
#(
  parameter int          ADDR_W   = 18,
  parameter int          NFAULT   = 7,
  parameter logic [17:0] CSR_ADDR = 18'o777514,
  parameter logic [17:0] DBR_ADDR = 18'o777516
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NFAULT-1:0] fault_in,
  input  logic              pi_disable,
  output logic              irq,
  output logic              prn_valid,
  output logic              prn_adv,
  output logic [CHAR_W-1:0] prn_data,
  input  logic              prn_ack
);
  logic     sel_csr, sel_dbr, csr_wr, dbr_wr, accept;
  logic     err, ready, ie_q;
  logic [7:0] dbuf_q;
  prn_cmd_t dec_cmd, cur_cmd;

  assign sel_csr = (bus_addr == CSR_ADDR[ADDR_W-1:0]);
  assign sel_dbr = (bus_addr == DBR_ADDR[ADDR_W-1:0]);
  assign csr_wr  = bus_wr & sel_csr;
  assign dbr_wr  = bus_wr & sel_dbr;
  assign accept  = dbr_wr & ready;

  lpt_fault_agg #(.NFAULT(NFAULT)) u_fault (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .err(err)
  );

  lpt_cmd_decode u_dec (
    .wbyte(bus_wdata[7:0]), .pi_disable(pi_disable), .cmd(dec_cmd)
  );

  lpt_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .load(dbr_wr), .cmd_in(dec_cmd),
    .ack(prn_ack), .valid(prn_valid), .ready(ready), .cmd_out(cur_cmd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      dbuf_q <= '0;
    end else begin
      if (csr_wr) ie_q   <= bus_wdata[IE_BIT];
      if (accept) dbuf_q <= bus_wdata[7:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_csr) begin
      bus_rdata[ERR_BIT] = err;
      bus_rdata[RDY_BIT] = ready;
      bus_rdata[IE_BIT]  = ie_q;
    end else if (sel_dbr) begin
      bus_rdata[7:0] = dbuf_q;
    end
  end

  assign irq      = ie_q & (err | ready);
  assign prn_adv  = cur_cmd.adv;
  assign prn_data = cur_cmd.data;

  p_ie_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr |=> (ie_q == $past(bus_wdata[IE_BIT])));
  p_irq_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q && err) |-> irq);
  p_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dbr_wr && !ready) |=> ($stable(dbuf_q) && $stable(cur_cmd)));
  p_adv_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pi_disable) |=> !prn_adv);
endmodule

// File: tb/lpt_ctrl_tb.sv
module lpt_ctrl_tb;
  localparam logic [17:0] CSR = 18'o777514;
  localparam logic [17:0] DBR = 18'o777516;
  localparam int NV = 8;
  // fields: wdata[15:0], pi_disable, exp_adv, exp_data[6:0]
  localparam logic [24:0] VEC [NV] = '{
    {16'h0041, 1'b0, 1'b0, 7'h41},
    {16'h00C1, 1'b0, 1'b0, 7'h41},
    {16'h0095, 1'b0, 1'b1, 7'h05},
    {16'h009F, 1'b0, 1'b1, 7'h0F},
    {16'h0090, 1'b0, 1'b1, 7'h00},
    {16'h0095, 1'b1, 1'b0, 7'h15},
    {16'hFF7E, 1'b0, 1'b0, 7'h7E},
    {16'h001F, 1'b0, 1'b0, 7'h1F}
  };

  logic clk = 0, rst_n = 0, bus_wr = 0, pi_disable = 0, prn_ack = 0;
  logic [17:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata, rd;
  logic [6:0]  fault_in = '0;
  logic irq, prn_valid, prn_adv;
  logic [6:0] prn_data;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  lpt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_in(fault_in),
    .pi_disable(pi_disable), .irq(irq), .prn_valid(prn_valid),
    .prn_adv(prn_adv), .prn_data(prn_data), .prn_ack(prn_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [17:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rdreg(input logic [17:0] a, output logic [15:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic ack_pulse();
    @(negedge clk); prn_ack = 1;
    @(negedge clk); prn_ack = 0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", prn_valid, 0);
    chk("R1 irq", irq, 0);
    rdreg(CSR, rd); chk("R1 csr", rd, 16'h0080);
    rdreg(DBR, rd); chk("R1 dbr", rd, 16'h0000);

    // table walk: R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      pi_disable = VEC[i][8];
      wr(DBR, VEC[i][24:9]);
      chk("R6 valid", prn_valid, 1);
      chk("R7/R8 adv", prn_adv, VEC[i][7]);
      chk("R7/R8 data", prn_data, VEC[i][6:0]);
      rdreg(CSR, rd); chk("R6 ready low", rd, 16'h0000);
      rdreg(DBR, rd); chk("R11 readback", rd, {8'h00, VEC[i][16:9]});
      @(negedge clk);
      chk("R9 hold valid", prn_valid, 1);
      chk("R9 hold data", {prn_adv, prn_data}, VEC[i][7:0]);
      ack_pulse();
      chk("R9 valid drop", prn_valid, 0);
      rdreg(CSR, rd); chk("R9 ready back", rd, 16'h0080);
    end
    pi_disable = 0;

    // R9 ack without valid ignored
    ack_pulse();
    chk("R9 stray ack valid", prn_valid, 0);
    rdreg(CSR, rd); chk("R9 stray ack ready", rd, 16'h0080);

    // R2 R4 R5 interrupt enable
    wr(CSR, 16'h0040);
    rdreg(CSR, rd); chk("R4 ie set", rd, 16'h00C0);
    chk("R5 irq ready", irq, 1);
    wr(CSR, 16'hFFFF);
    rdreg(CSR, rd); chk("R2 other bits ignored", rd, 16'h00C0);
    wr(CSR, 16'h0000);
    rdreg(CSR, rd); chk("R4 ie clear", rd, 16'h0080);
    chk("R5 irq off", irq, 0);

    // R3 each fault bit
    for (int b = 0; b < 7; b++) begin
      @(negedge clk); fault_in = 7'(1 << b);
      @(negedge clk); rdreg(CSR, rd); chk("R3 err set", rd, 16'h8080);
    end
    fault_in = 7'h7F;
    wr(CSR, 16'h0040);
    wr(DBR, 16'h0033);
    chk("R5 irq err", irq, 1);
    @(negedge clk); fault_in = '0;
    @(negedge clk); rdreg(CSR, rd); chk("R3 err clear", rd, 16'h0040);
    chk("R5 irq idle busy", irq, 0);

    // R10 discard while busy
    wr(DBR, 16'h0042);
    rdreg(DBR, rd); chk("R10 buffer kept", rd, 16'h0033);
    chk("R10 payload kept", prn_data, 7'h33);
    ack_pulse();
    chk("R5 irq ready again", irq, 1);

    // R12 other address
    wr(18'o777512, 16'h0000);
    rdreg(CSR, rd); chk("R12 csr untouched", rd, 16'h00C0);
    wr(18'o777520, 16'h0055);
    chk("R12 no transfer", prn_valid, 0);
    rdreg(18'o777520, rd); chk("R12 read zero", rd, 16'h0000);
    rdreg(DBR, rd); chk("R12 dbr untouched", rd, 16'h0033);

    // R1 reset mid-transfer
    wr(DBR, 16'h0050);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 re-reset valid", prn_valid, 0);
    rdreg(CSR, rd); chk("R1 re-reset csr", rd, 16'h0080);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule